// File: doc/BRIEF.md
# SPI Full-Duplex Receive Capture

This block sits next to an SPI host controller and records what the target sends back while the host drives the bus. It watches the host's serial clock, its chip selects and the MISO pin. While a chip select is asserted and capture is enabled, it assembles MISO bits into bytes. It then packs those bytes into a circular buffer of 64-bit entries that software reads through a simple read port. The host engine keeps sole control of the outgoing side. The block never drives SCLK or MOSI.

The bus signals are sampled in the block's own clock domain through synchronizers, and edges are detected there. The bus clock must therefore run well below the block clock. Each received byte is stored with its bit order reversed, so the first bit off the wire lands in bit 0. Bytes fill the lanes of an entry from lane 0 upward. When an entry is full, the write index moves on and wraps around the end of the buffer, so capture can run longer than the buffer holds. A transfer that ends partway through an entry still uses that whole entry, and the next transfer starts on the following one.

A per-chip-select hold field forces a chip-select output low whatever the host requests. A transaction can then span several host commands, and its length is left open.

Top module: `spi_duplex_capture`

## Requirements
- R1: The control word has these fields: bit 0 = start, bit 2 = capture edge, bit 4 = receive enable, bits 9:6 = chip-select hold (bit 6+i for chip select i), bit 11 = session enable. Bits 1, 3, 5 and 10 are stored and have no function. `ctrl_rdata` returns the last written word with bit 0 reading as 0.
- R2: While hold bit i is set, `cs_n_out[i]` is 0 regardless of `host_cs_n[i]`. With the bit clear, `cs_n_out[i]` equals `host_cs_n[i]`.
- R3: Each stored byte is the bit reverse of the byte as sent MSB first on MISO. The first bit received lands in bit 0.
- R4: Within an entry, bits [8k+7:8k] hold the k-th byte received into that entry. Lanes not yet written in the current entry read as zero.
- R5: The write index advances by one after every 8 bytes in an entry and wraps from the last entry to entry 0. The default depth is 32 entries.
- R6: When the host deasserts all chip selects with a partly filled entry, that entry is kept and the next byte goes to lane 0 of the following entry.
- R7: Capture, advancing of the write index and flushing happen only while both receive enable and session enable are set.
- R8: With capture edge = 0, MISO is sampled on rising SCLK edges. With capture edge = 1, it is sampled on falling edges.
- R9: Writing the control word with start = 1 resets the write index and the lane position to zero.
- R10: Bits of an incomplete byte are discarded when the host deasserts all chip selects. They do not shift into the next byte.
- R11: `rd_data` shows entry `rd_entry` one clock after the address is presented. Reads do not change the capture state.
- R12: After reset the control word is zero, `cs_n_out` follows `host_cs_n`, and the first captured byte goes to lane 0 of entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 4 | Chip selects requested by the host, active low |
| sclk | input | 1 | Bus serial clock from the host |
| miso | input | 1 | Serial data from the target |
| cs_n_out | output | 4 | Chip selects to the pins, after the hold override |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 12 | Control word write value |
| ctrl_rdata | output | 12 | Control word read value |
| rd_entry | input | 5 | Buffer entry to read |
| rd_data | output | 64 | Buffer entry contents, one cycle after `rd_entry` |

## Verification
The bench sweeps transfers of 1 to 20 bytes, which drives the write index past the end of the buffer. A design that mishandled the wrap, or that did not move to a fresh entry after a partial one, would overwrite the wrong entry or leave stale lanes. On every bit, MISO carries one value at the rising edge and a different value at the falling edge. A design sampling on the wrong edge would therefore store complemented data, and one that reversed the bit order or the lane order would show a permuted entry. Further sequences cover a chip select dropped mid-byte, capture with either enable bit clear, a start in mid-session, and hold overrides on idle chip selects. Each of these would leak stray bits, move the index, or leave the pins wrong if handled badly.

// File: rtl/spi_duplex_capture.sv
module spi_duplex_capture #(
  parameter int DEPTH = 32,
  parameter int SYNC  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       host_cs_n,
  input  logic             sclk,
  input  logic             miso,
  output logic [3:0]       cs_n_out,
  input  logic             ctrl_we,
  input  logic [11:0]      ctrl_wdata,
  output logic [11:0]      ctrl_rdata,
  input  logic [IDX_W-1:0] rd_entry,
  output logic [63:0]      rd_data
);

  logic [11:0]      ctrl_q;
  logic [SYNC:0]    sclk_s;
  logic [SYNC:0]    cs_s;
  logic [SYNC-1:0]  miso_s;
  logic [IDX_W-1:0] wr_idx;
  logic [2:0]       lane;
  logic [2:0]       bitcnt;
  logic [7:0]       sh;
  logic [63:0]      acc;
  logic [63:0]      mem [DEPTH];
  logic [63:0]      mem_word;

  wire cap_en   = ctrl_q[11] & ctrl_q[4];
  wire start    = ctrl_we & ctrl_wdata[0];
  wire s_rise   = sclk_s[SYNC-1] & ~sclk_s[SYNC];
  wire s_fall   = ~sclk_s[SYNC-1] & sclk_s[SYNC];
  wire samp     = ctrl_q[2] ? s_fall : s_rise;
  wire act      = cs_s[SYNC-1];
  wire cs_end   = ~cs_s[SYNC-1] & cs_s[SYNC];
  wire [7:0] nbyte = {miso_s[SYNC-1], sh[7:1]};
  wire shift_en = ~start & cap_en & ~cs_end & act & samp;
  wire wr_now   = shift_en & (bitcnt == 3'd7);

  assign cs_n_out   = host_cs_n & ~ctrl_q[9:6];
  assign ctrl_rdata = ctrl_q;

  always_comb begin
    mem_word = acc;
    mem_word[lane*8 +: 8] = nbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '0;
      miso_s <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC-1:0], sclk};
      cs_s   <= {cs_s[SYNC-1:0], ~&host_cs_n};
      miso_s <= {miso_s[SYNC-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wr_idx <= '0;
      lane   <= '0;
      bitcnt <= '0;
      sh     <= '0;
      acc    <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata & 12'hFFE;
      if (start) begin
        wr_idx <= '0;
        lane   <= '0;
        bitcnt <= '0;
        acc    <= '0;
      end else if (cap_en) begin
        if (cs_end) begin
          bitcnt <= '0;
          if (lane != 3'd0) begin
            wr_idx <= wr_idx + 1'b1;
            lane   <= '0;
            acc    <= '0;
          end
        end else if (shift_en) begin
          bitcnt <= bitcnt + 1'b1;
          sh     <= nbyte;
          if (bitcnt == 3'd7) begin
            if (lane == 3'd7) begin
              wr_idx <= wr_idx + 1'b1;
              lane   <= '0;
              acc    <= '0;
            end else begin
              lane <= lane + 1'b1;
              acc  <= mem_word;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_now) mem[wr_idx] <= mem_word;
    rd_data <= mem[rd_entry];
  end

endmodule

module spi_duplex_capture_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic [11:0]      ctrl_wdata,
  input logic [3:0]       cs_n_out,
  input logic [IDX_W-1:0] wr_idx,
  input logic [2:0]       lane,
  input logic             cap_en
);

  AST_HOLD_FORCES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && (&ctrl_wdata[9:6])) |=> (cs_n_out == 4'h0)); // R2

  AST_START_CLEARS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[0]) |=> (wr_idx == '0 && lane == 3'd0)); // R9

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx != $past(wr_idx)) |-> (wr_idx == IDX_W'($past(wr_idx) + 1'b1) || wr_idx == '0)); // R5

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !(ctrl_we && ctrl_wdata[0])) |=> ($stable(wr_idx) && $stable(lane))); // R7

endmodule

bind spi_duplex_capture spi_duplex_capture_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_spi_duplex_capture.sv
module test_spi_duplex_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_cs_n = 4'hF;
  logic sclk = 1'b0;
  logic miso = 1'b0;
  logic [3:0] cs_n_out;
  logic ctrl_we = 1'b0;
  logic [11:0] ctrl_wdata = '0;
  logic [11:0] ctrl_rdata;
  logic [4:0] rd_entry = '0;
  logic [63:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] exp_mem [DEPTH];
  int exp_idx = 0;
  int exp_lane = 0;
  logic pol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_duplex_capture i_spi_duplex_capture (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .sclk(sclk), .miso(miso),
    .cs_n_out(cs_n_out), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .rd_entry(rd_entry), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic wr_ctrl(logic [11:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    pol = v[2];
    if (v[0]) begin
      exp_idx = 0;
      exp_lane = 0;
    end
  endtask

  task automatic rd_chk(string req, int e);
    @(negedge clk);
    rd_entry = 5'(e);
    @(negedge clk);
    chk(req, rd_data, exp_mem[e]);
  endtask

  // rising edge sees bits of r, falling edge sees bits of f
  task automatic send_bits(logic [7:0] r, logic [7:0] f, int nb);
    for (int i = 0; i < nb; i++) begin
      miso = r[7-i];
      cyc(8);
      sclk = 1'b1;
      cyc(4);
      miso = f[7-i];
      cyc(4);
      sclk = 1'b0;
      cyc(4);
    end
  endtask

  task automatic model_byte(logic [7:0] wire_byte);
    if (exp_lane == 0) exp_mem[exp_idx] = '0;
    exp_mem[exp_idx][exp_lane*8 +: 8] = rev8(wire_byte);
    exp_lane++;
    if (exp_lane == 8) begin
      exp_lane = 0;
      exp_idx = (exp_idx + 1) % DEPTH;
    end
  endtask

  task automatic model_flush();
    if (exp_lane != 0) begin
      exp_lane = 0;
      exp_idx = (exp_idx + 1) % DEPTH;
    end
  endtask

  task automatic cs_on();
    host_cs_n[0] = 1'b0;
    cyc(6);
  endtask

  task automatic cs_off();
    cyc(6);
    host_cs_n[0] = 1'b1;
    cyc(6);
  endtask

  // full transfer of len bytes with capture enabled; checks the touched entries
  task automatic xfer(string req, int len, int seed);
    int first;
    int used;
    logic [7:0] r;
    first = exp_idx;
    used = (exp_lane + len + 7) / 8;
    cs_on();
    for (int k = 0; k < len; k++) begin
      r = 8'((seed * 37 + k * 11 + 5) ^ 8'hA5);
      send_bits(r, ~r, 8);
      model_byte(pol ? ~r : r);
    end
    cs_off();
    model_flush();
    for (int j = 0; j < used; j++) rd_chk(req, (first + j) % DEPTH);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R12: reset state
    chk("R12 ctrl reset", 64'(ctrl_rdata), 64'h0);
    chk("R12 cs follows host", 64'(cs_n_out), 64'hF);
    host_cs_n = 4'b1010;
    cyc(1);
    chk("R2 no hold passes host", 64'(cs_n_out), 64'hA);
    host_cs_n = 4'hF;

    // R12/R3/R4: first bytes land at entry 0 lane 0 without a start
    wr_ctrl(12'h810);
    chk("R1 readback", 64'(ctrl_rdata), 64'h810);
    xfer("R12 first entry", 3, 99);

    // R5/R6/R3/R4/R8: length sweep with wrap, rising-edge capture
    wr_ctrl(12'h811);
    for (int len = 1; len <= 20; len++) xfer("R5 R6 sweep rising", len, len);

    // R8: falling-edge capture
    wr_ctrl(12'h814);
    for (int len = 7; len <= 10; len++) xfer("R8 sweep falling", len, len + 50);

    // R1: start bit reads back zero, other fields stored
    wr_ctrl(12'h8D5);
    chk("R1 start reads zero", 64'(ctrl_rdata), 64'h8D4);
    chk("R2 hold cs0 cs1", 64'(cs_n_out), 64'hC);
    host_cs_n = 4'h0;
    cyc(1);
    chk("R2 hold with host low", 64'(cs_n_out), 64'h0);
    host_cs_n = 4'hF;
    wr_ctrl(12'h814);
    chk("R2 hold released", 64'(cs_n_out), 64'hF);

    // R9: start resets to entry 0
    xfer("R9 pre", 5, 7);
    wr_ctrl(12'h811);
    chk("R9 idx reset", 64'(exp_idx), 64'h0);
    xfer("R9 after start", 2, 8);

    // R10: partial byte discarded at chip-select end
    cs_on();
    send_bits(8'hFF, 8'h00, 5);
    cs_off();
    xfer("R10 partial bits dropped", 1, 9);

    // R7: receive enable clear, then session enable clear
    wr_ctrl(12'h800);
    cs_on();
    send_bits(8'h3C, 8'hC3, 8);
    send_bits(8'h5A, 8'hA5, 8);
    cs_off();
    rd_chk("R7 rx off no write", exp_idx);
    wr_ctrl(12'h010);
    cs_on();
    send_bits(8'h96, 8'h69, 8);
    cs_off();
    rd_chk("R7 session off no write", exp_idx);
    wr_ctrl(12'h810);
    xfer("R7 index unchanged", 2, 11);

    // R11: reads of every entry, then capture continues in place
    for (int e = 0; e < DEPTH; e++) rd_chk("R11 read all", e);
    xfer("R11 reads no side effect", 9, 12);

    // R2 per chip select
    for (int i = 0; i < 4; i++) begin
      wr_ctrl(12'h810 | (12'h040 << i));
      chk("R2 single hold", 64'(cs_n_out), 64'(4'hF & ~(4'h1 << i)));
    end
    wr_ctrl(12'h810);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule